// File: doc/BRIEF.md
# Two-Stage Keyed Watchdog Timer

This block watches for software that has stopped making progress. Once the `enable` input goes high, a wide primary down-counter starts from a programmable load value and steps down on every clock. If software lets it run out, the block raises `irq` and starts a narrow secondary down-counter. The secondary counter steps only once every sixteen clocks, through a prescaler. If the secondary counter also runs out, the block raises `fail_req`, a request for the rest of the chip to reset itself.

Software keeps the watchdog quiet by writing one exact 32-bit key to the restart register. Any other value written there changes nothing. Software can also raise `fail_req` on purpose through a control bit. Once `fail_req` is high, only the asynchronous reset `rst_n` can clear it.

The control sits in a four-state machine. The states are `ST_IDLE` (disabled), `ST_PRIMARY` (primary counting), `ST_SECONDARY` (secondary counting) and `ST_FAILED` (terminal). These are its transitions:
- `enable` high moves IDLE to PRIMARY.
- The primary count reaching zero moves PRIMARY to SECONDARY (expiry).
- A valid key moves SECONDARY back to PRIMARY.
- A secondary tick at zero moves SECONDARY to FAILED.
- `enable` low moves PRIMARY or SECONDARY to IDLE.
- The force bit moves any state to FAILED.

Top module: `keyed_wdt`

Register offsets (`addr`):

| Offset | Register | Access | Contents |
|---|---|---|---|
| 0 | primary load | read/write | primary start value |
| 1 | secondary load | read/write | secondary start value, low 8 bits |
| 2 | restart | write only | reads as 0 |
| 3 | control | write | bit 0 = force failure |
| 4 | status | read; write 1 to clear bit 0 | bit 0 = irq, bit 1 = fail |
| 5 | primary count | read only | live primary counter |
| 6 | secondary count | read only | live secondary counter |

## Requirements
- R1: After `rst_n` the outputs `irq` and `fail_req` are 0 and the load registers hold their reset defaults. While `enable` stays low, the primary count does not change.
- R2: On the clock edge that first samples `enable` high, the primary counter is loaded with L, the value of the primary load register (offset 0). It then steps down by one on every edge. `irq` rises on the edge L+1 edges after the enable edge.
- R3: At expiry, the secondary counter is loaded with S, the value of the secondary load register (offset 1), and the prescaler is cleared. The secondary counter then steps once every 16 clocks. `fail_req` rises 16*(S+1) edges after the edge that raised `irq`.
- R4: Writing the key 0x5AFEC0DE to the restart register (offset 2) has these effects on that edge:
  - the primary counter reloads;
  - the secondary counter stops and reloads;
  - `irq` clears.
  The next `irq` follows L+1 edges after the write edge.
- R5: Writing any value other than the key to offset 2 has no effect on either counter or on `irq`.
- R6: Writing 1 to bit 0 of the status register (offset 4) clears `irq` and leaves the secondary countdown running. Writing 0 there has no effect. If expiry falls on the same edge as a clear, `irq` is set.
- R7: Writing 1 to bit 0 of the control register (offset 3) raises `fail_req` on that edge, from any state.
- R8: Once high, `fail_req` stays high until `rst_n`. Dropping `enable` does not clear it, and neither does writing the key.
- R9: Dropping `enable` before failure stops counting (IDLE). The next enable edge restarts the primary counter from L.
- R10: Read-back values on `rdata`:
  - offsets 0 and 1 return the load values;
  - offset 2 reads as 0;
  - offset 4 returns `irq` in bit 0 and `fail_req` in bit 1;
  - offsets 5 and 6 return the live counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | peripheral clock |
| rst_n | input | 1 | asynchronous reset, active low |
| enable | input | 1 | watchdog run enable |
| wr_en | input | 1 | register write strobe |
| addr | input | 3 | register offset |
| wdata | input | 32 | write data |
| rdata | output | 32 | read data for `addr` |
| irq | output | 1 | primary expiry interrupt |
| fail_req | output | 1 | reset request |

## Verification
The bench builds the block with 32-bit primary and 8-bit secondary counters, a divide-by-16 prescaler and the default key. It overrides the reset loads to 20 and 1, so the reset-default timing can be timed in full within a few dozen clocks. Reprogrammed load values from 0 to 1000 reach the zero-load corner and both expiry paths. They also reach the exact 16*(S+1) secondary window, where a prescaler that was not cleared would show up as an offset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRIMARY,
        ST_SECONDARY,
        ST_FAILED
    } wdt_state_t;

    localparam int unsigned REG_ADDR_W = 3;

    localparam logic [REG_ADDR_W-1:0] OFF_PRI_LOAD = 3'd0;
    localparam logic [REG_ADDR_W-1:0] OFF_SEC_LOAD = 3'd1;
    localparam logic [REG_ADDR_W-1:0] OFF_RESTART  = 3'd2;
    localparam logic [REG_ADDR_W-1:0] OFF_CTRL     = 3'd3;
    localparam logic [REG_ADDR_W-1:0] OFF_STATUS   = 3'd4;
    localparam logic [REG_ADDR_W-1:0] OFF_PRI_CNT  = 3'd5;
    localparam logic [REG_ADDR_W-1:0] OFF_SEC_CNT  = 3'd6;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PRI_W  = 32,
    parameter int unsigned SEC_W  = 8,
    parameter logic [DATA_W-1:0] KEY       = 32'h5AFE_C0DE,
    parameter logic [PRI_W-1:0]  PRI_RESET = '1,
    parameter logic [SEC_W-1:0]  SEC_RESET = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [PRI_W-1:0]      pri_cnt,
    input  logic [SEC_W-1:0]      sec_cnt,
    input  logic                  irq,
    input  logic                  fail_req,
    output logic [PRI_W-1:0]      pri_load,
    output logic [SEC_W-1:0]      sec_load,
    output logic                  restart_hit,
    output logic                  force_hit,
    output logic                  irq_clr,
    output logic [DATA_W-1:0]     rdata
);
    logic sel_pri, sel_sec, sel_rst, sel_ctl, sel_sts;

    always_comb begin
        sel_pri = wr_en && (addr == OFF_PRI_LOAD);
        sel_sec = wr_en && (addr == OFF_SEC_LOAD);
        sel_rst = wr_en && (addr == OFF_RESTART);
        sel_ctl = wr_en && (addr == OFF_CTRL);
        sel_sts = wr_en && (addr == OFF_STATUS);
    end

    assign restart_hit = sel_rst && (wdata == KEY);
    assign force_hit   = sel_ctl && wdata[0];
    assign irq_clr     = sel_sts && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pri_load <= PRI_RESET;
            sec_load <= SEC_RESET;
        end else begin
            if (sel_pri) pri_load <= wdata[PRI_W-1:0];
            if (sel_sec) sec_load <= wdata[SEC_W-1:0];
        end
    end

    always_comb begin
        case (addr)
            OFF_PRI_LOAD: rdata = DATA_W'(pri_load);
            OFF_SEC_LOAD: rdata = DATA_W'(sec_load);
            OFF_STATUS:   rdata = DATA_W'({fail_req, irq});
            OFF_PRI_CNT:  rdata = DATA_W'(pri_cnt);
            OFF_SEC_CNT:  rdata = DATA_W'(sec_cnt);
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int unsigned DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_bypass
            assign tick = run && !clear;
        end else begin : g_count
            localparam int unsigned PRE_W = $clog2(DIV);
            localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);
            logic [PRE_W-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (clear) begin
                    cnt <= '0;
                end else if (run) begin
                    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
                end
            end

            assign tick = run && !clear && (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int unsigned PRI_W = 32,
    parameter int unsigned SEC_W = 8,
    parameter logic [PRI_W-1:0] PRI_RESET = '1,
    parameter logic [SEC_W-1:0] SEC_RESET = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PRI_W-1:0] pri_load,
    input  logic [SEC_W-1:0] sec_load,
    input  logic             restart_hit,
    input  logic             force_hit,
    input  logic             irq_clr,
    input  logic             sec_tick,
    output wdt_state_t       state_q,
    output logic [PRI_W-1:0] pri_cnt,
    output logic [SEC_W-1:0] sec_cnt,
    output logic             pre_clear,
    output logic             pre_run,
    output logic             irq,
    output logic             fail_req
);
    wdt_state_t state_d;
    logic pri_zero, sec_zero;
    logic expire, enter_pri, pri_step, sec_step;

    assign pri_zero = (pri_cnt == '0);
    assign sec_zero = (sec_cnt == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) state_d = ST_PRIMARY;
            end
            ST_PRIMARY: begin
                if (!enable)                        state_d = ST_IDLE;
                else if (!restart_hit && pri_zero)  state_d = ST_SECONDARY;
            end
            ST_SECONDARY: begin
                if (!enable)                  state_d = ST_IDLE;
                else if (restart_hit)         state_d = ST_PRIMARY;
                else if (sec_tick && sec_zero) state_d = ST_FAILED;
            end
            ST_FAILED: begin
                state_d = ST_FAILED;
            end
        endcase
        if (force_hit) state_d = ST_FAILED;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        expire    = (state_q == ST_PRIMARY)   && (state_d == ST_SECONDARY);
        enter_pri = (state_q == ST_IDLE)      && (state_d == ST_PRIMARY);
        pri_step  = (state_q == ST_PRIMARY)   && (state_d == ST_PRIMARY) && !pri_zero;
        sec_step  = (state_q == ST_SECONDARY) && (state_d == ST_SECONDARY) && sec_tick;
        pre_clear = expire || restart_hit;
        pre_run   = (state_q == ST_SECONDARY);
    end

    // counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pri_cnt <= PRI_RESET;
            sec_cnt <= SEC_RESET;
        end else begin
            if (restart_hit || enter_pri) pri_cnt <= pri_load;
            else if (pri_step)            pri_cnt <= pri_cnt - 1'b1;

            if (restart_hit || expire)    sec_cnt <= sec_load;
            else if (sec_step)            sec_cnt <= sec_cnt - 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            fail_req <= 1'b0;
        end else begin
            if (expire)                      irq <= 1'b1;
            else if (restart_hit || irq_clr) irq <= 1'b0;
            fail_req <= (state_d == ST_FAILED);
        end
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned PRI_W   = 32,
    parameter int unsigned SEC_W   = 8,
    parameter int unsigned PRE_DIV = 16,
    parameter logic [DATA_W-1:0] KEY       = 32'h5AFE_C0DE,
    parameter logic [PRI_W-1:0]  PRI_RESET = '1,
    parameter logic [SEC_W-1:0]  SEC_RESET = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic                  irq,
    output logic                  fail_req
);
    wdt_state_t       state_q;
    logic [PRI_W-1:0] pri_load, pri_cnt;
    logic [SEC_W-1:0] sec_load, sec_cnt;
    logic restart_hit, force_hit, irq_clr;
    logic pre_clear, pre_run, sec_tick;

    wdt_regs #(
        .DATA_W(DATA_W), .PRI_W(PRI_W), .SEC_W(SEC_W),
        .KEY(KEY), .PRI_RESET(PRI_RESET), .SEC_RESET(SEC_RESET)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pri_cnt(pri_cnt), .sec_cnt(sec_cnt), .irq(irq), .fail_req(fail_req),
        .pri_load(pri_load), .sec_load(sec_load), .restart_hit(restart_hit),
        .force_hit(force_hit), .irq_clr(irq_clr), .rdata(rdata)
    );

    wdt_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(pre_clear), .run(pre_run), .tick(sec_tick)
    );

    wdt_ctrl #(
        .PRI_W(PRI_W), .SEC_W(SEC_W), .PRI_RESET(PRI_RESET), .SEC_RESET(SEC_RESET)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pri_load(pri_load),
        .sec_load(sec_load), .restart_hit(restart_hit), .force_hit(force_hit),
        .irq_clr(irq_clr), .sec_tick(sec_tick), .state_q(state_q),
        .pri_cnt(pri_cnt), .sec_cnt(sec_cnt), .pre_clear(pre_clear),
        .pre_run(pre_run), .irq(irq), .fail_req(fail_req)
    );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int unsigned PRI_W = 32,
    parameter int unsigned SEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input wdt_state_t       state_q,
    input logic [PRI_W-1:0] pri_cnt,
    input logic [SEC_W-1:0] sec_cnt,
    input logic             sec_tick,
    input logic             restart_hit,
    input logic             force_hit,
    input logic             irq,
    input logic             fail_req
);
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !enable && !restart_hit) |=> $stable(pri_cnt));

    assert_pri_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIMARY && enable && !restart_hit && !force_hit && pri_cnt != '0)
        |=> (pri_cnt == $past(pri_cnt) - 1'b1));

    assert_irq_from_primary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(state_q) == ST_PRIMARY));

    assert_sec_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SECONDARY && enable && !sec_tick && !restart_hit && !force_hit)
        |=> $stable(sec_cnt));

    assert_key_clears_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart_hit |=> !irq);

    assert_force_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        force_hit |=> fail_req);

    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_req |=> fail_req);
endmodule

bind keyed_wdt wdt_checker #(.PRI_W(PRI_W), .SEC_W(SEC_W)) u_wdt_checker (
    .clk(clk), .rst_n(rst_n), .enable(enable), .state_q(state_q),
    .pri_cnt(pri_cnt), .sec_cnt(sec_cnt), .sec_tick(sec_tick),
    .restart_hit(restart_hit), .force_hit(force_hit), .irq(irq), .fail_req(fail_req)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
    localparam logic [31:0] KEY = 32'h5AFE_C0DE;
    localparam int NV = 4;
    // primary load, secondary load, edges enable->irq, edges irq->fail
    localparam int VEC [NV][4] = '{
        '{3, 0, 4, 16},
        '{10, 2, 11, 48},
        '{0, 1, 1, 32},
        '{7, 3, 8, 64}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq, fail_req;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    keyed_wdt #(.PRI_RESET(32'd20), .SEC_RESET(8'd1)) u_keyed_wdt (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .fail_req(fail_req)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; enable = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, output int edge_no);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        edge_no = cyc;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_en(input logic v, output int edge_no);
        @(negedge clk);
        enable = v;
        @(negedge clk);
        edge_no = cyc;
    endtask

    task automatic wait_out(input bit use_fail, input string req, output int edge_no);
        int n = 0;
        while ((use_fail ? fail_req : irq) !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        edge_no = cyc;
        if (n >= 5000) chk({req, " timeout"}, 32'd0, 32'd1);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int e0, e1, e2, k;
        logic [31:0] v;

        // R1 reset state and idle hold
        do_reset();
        chk("R1 irq after reset", 32'(irq), 32'd0);
        chk("R1 fail after reset", 32'(fail_req), 32'd0);
        rd(3'd0, v); chk("R1 pri load default", v, 32'd20);
        rd(3'd1, v); chk("R1 sec load default", v, 32'd1);
        repeat (40) @(negedge clk);
        chk("R1 no irq while disabled", 32'(irq), 32'd0);
        rd(3'd5, v); chk("R1 pri count held", v, 32'd20);
        rd(3'd2, v); chk("R10 restart reads zero", v, 32'd0);

        // default loads: 20 / 1
        set_en(1'b1, e0);
        wait_out(1'b0, "R2", e1); chk("R2 irq delay default", 32'(e1 - e0), 32'd21);
        wait_out(1'b1, "R3", e2); chk("R3 fail delay default", 32'(e2 - e1), 32'd32);
        rd(3'd4, v); chk("R10 status irq+fail", v, 32'd3);

        // table of load values
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(3'd0, 32'(VEC[i][0]), k);
            wr(3'd1, 32'(VEC[i][1]), k);
            rd(3'd0, v); chk("R10 pri load readback", v, 32'(VEC[i][0]));
            rd(3'd1, v); chk("R10 sec load readback", v, 32'(VEC[i][1]));
            set_en(1'b1, e0);
            wait_out(1'b0, "R2", e1); chk("R2 irq delay table", 32'(e1 - e0), 32'(VEC[i][2]));
            wait_out(1'b1, "R3", e2); chk("R3 fail delay table", 32'(e2 - e1), 32'(VEC[i][3]));
        end

        // R5 wrong keys ignored
        do_reset();
        wr(3'd0, 32'd30, k);
        set_en(1'b1, e0);
        wr(3'd2, KEY ^ 32'd1, k);
        wr(3'd2, 32'd0, k);
        wait_out(1'b0, "R5", e1); chk("R5 irq delay after bad keys", 32'(e1 - e0), 32'd31);
        wr(3'd2, ~KEY, k);
        chk("R5 irq kept after bad key", 32'(irq), 32'd1);
        wait_out(1'b1, "R5", e2); chk("R5 fail delay after bad key", 32'(e2 - e1), 32'd32);

        // R4 restart in primary and secondary
        do_reset();
        wr(3'd0, 32'd20, k);
        wr(3'd1, 32'd2, k);
        set_en(1'b1, e0);
        repeat (5) @(negedge clk);
        wr(3'd2, KEY, k);
        wait_out(1'b0, "R4", e1); chk("R4 irq after primary restart", 32'(e1 - k), 32'd21);
        repeat (20) @(negedge clk);
        wr(3'd2, KEY, k);
        chk("R4 irq cleared by key", 32'(irq), 32'd0);
        rd(3'd6, v); chk("R4 sec reloaded", v, 32'd2);
        wait_out(1'b0, "R4", e1); chk("R4 irq after secondary restart", 32'(e1 - k), 32'd21);
        chk("R4 no fail after restart", 32'(fail_req), 32'd0);
        wait_out(1'b1, "R4", e2); chk("R4 fail after new window", 32'(e2 - e1), 32'd48);

        // R6 write-one-to-clear
        do_reset();
        wr(3'd0, 32'd5, k);
        wr(3'd1, 32'd3, k);
        set_en(1'b1, e0);
        wait_out(1'b0, "R6", e1);
        wr(3'd4, 32'd0, k);
        chk("R6 zero write keeps irq", 32'(irq), 32'd1);
        wr(3'd4, 32'd1, k);
        chk("R6 one write clears irq", 32'(irq), 32'd0);
        wait_out(1'b1, "R6", e2); chk("R6 secondary keeps running", 32'(e2 - e1), 32'd64);

        // R7 force, R8 sticky
        do_reset();
        wr(3'd0, 32'd1000, k);
        set_en(1'b1, e0);
        wr(3'd3, 32'd1, k);
        chk("R7 forced fail", 32'(fail_req), 32'd1);
        chk("R7 no irq on force", 32'(irq), 32'd0);
        set_en(1'b0, k);
        wr(3'd2, KEY, k);
        repeat (10) @(negedge clk);
        chk("R8 fail sticky", 32'(fail_req), 32'd1);
        rd(3'd4, v); chk("R10 status fail only", v, 32'd2);
        do_reset();
        chk("R8 reset clears fail", 32'(fail_req), 32'd0);
        wr(3'd3, 32'd1, k);
        chk("R7 force from idle", 32'(fail_req), 32'd1);

        // R9 disable stops, re-enable reloads
        do_reset();
        wr(3'd0, 32'd10, k);
        set_en(1'b1, e0);
        repeat (5) @(negedge clk);
        set_en(1'b0, k);
        repeat (30) @(negedge clk);
        chk("R9 no irq while disabled", 32'(irq), 32'd0);
        set_en(1'b1, e0);
        wait_out(1'b0, "R9", e1); chk("R9 irq delay after re-enable", 32'(e1 - e0), 32'd11);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule